// File: doc/BRIEF.md
# PLL Control and Clock-Divide Sequencer

This block is the digital side of an on-chip clock multiplier. It keeps a 5-bit multiplier ratio and a status word. The status word holds a 2-bit output-divide code, a PLL-off bit and a lock flag. It decides which clock-tick stream feeds the core: the raw oscillator ticks or the multiplied ticks. It then divides that stream by 8, 4, 2 or 1 to produce a one-cycle CPU clock enable. The whole block runs on one fast clock. Both the oscillator clock and the multiplied clock arrive as enable streams (`osc_en`, `vco_en`).

Software writes through a simple write port guarded by a protection-unlock input. The block refuses orderings that could overclock the core. It refuses a ratio change while the divider is not at /8, and a divider raise before the loop has locked. It refuses /1 while the multiplied clock is in use, and switching the loop off while a ratio is programmed. A refused write leaves the registers unchanged and raises a sticky error bit. Analog lock detection is replaced by a counter of oscillator ticks, restarted by each accepted ratio write. Only the main reset clears the registers. A secondary reset (used for debugger or missing-clock resets) only restarts the divider phase.

Top module: `pll_clk_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, ratio, divide code, PLL-off, lock flag and error bit all read 0. The CPU enable then pulses once every 8 oscillator ticks.
- R2: Divide code 0 gives one `cpu_en` pulse per 8 source ticks, code 1 one per 4, code 2 one per 2, and code 3 one per source tick.
- R3: A ratio write (address 0, ratio in data bits [4:0]) is accepted only when the divide code is 0 and it does not load a nonzero ratio while PLL-off is set. Otherwise the ratio is unchanged and the error bit sets.
- R4: After an accepted nonzero ratio write, the lock flag is 0 and the source is the oscillator stream. Once `lock_cycles` further oscillator ticks have been counted (0 counts as 1), the lock flag reads 1 and the source becomes `vco_en`.
- R5: While the ratio is nonzero, a status write (address 1, divide code in data bits [1:0]) with code 0 is always accepted. Codes 1 and 2 are accepted only when locked, and code 3 is always refused. A refused write leaves every field unchanged and sets the error bit.
- R6: A status write with data bit 2 set (PLL-off) is accepted only when the ratio is 0. While PLL-off is set, the source is the oscillator stream and all four divide codes, /1 included, are allowed.
- R7: With `wr_unlock` low, writes change no register and do not set the error bit.
- R8: Holding `soft_rst_n` low changes none of ratio, divide code, PLL-off, lock flag or error bit. It only restarts the divider phase.
- R9: A new divide code takes effect only at the end of the current divide period, so no `cpu_en` interval is cut short.
- R10: The error bit stays set until an accepted status write with data bit 3 set clears it. If the same write is refused, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; every other signal is sampled on its rising edge |
| rst_n | input | 1 | Main synchronous active-low reset (external or watchdog) |
| soft_rst_n | input | 1 | Secondary synchronous active-low reset; restarts the divider phase only |
| osc_en | input | 1 | Oscillator tick enable |
| vco_en | input | 1 | Multiplied-clock tick enable |
| lock_cycles | input | LOCK_W | Oscillator ticks needed to declare lock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = ratio register, 1 = status register |
| wr_data | input | 8 | Write data |
| wr_unlock | input | 1 | Protection unlock; writes count only while high |
| ratio_q | output | RATIO_W | Current multiplier ratio |
| divsel_q | output | DIV_W | Current divide code |
| pll_off_q | output | 1 | PLL-off bit |
| locked_q | output | 1 | Lock flag |
| wr_err_q | output | 1 | Sticky refused-write flag |
| cpu_en | output | 1 | CPU clock enable, one cycle per divided period |

## Verification
The embedded properties watch, every cycle, the invariants that must never break. No /1 with a nonzero ratio, PLL-off only with a zero ratio, no raised divider without lock. They also check that protected or refused writes leave the registers still, that a ratio write drops lock, and that the active divisor moves only at a period boundary. The bench scenarios are needed for the results that depend on sequences. These are the actual pulse spacing for each divide code and source, the lock delay in oscillator ticks, the exact interval across a divider change, and error clearing. They also show that the secondary reset leaves every register intact.

// File: rtl/pll_ctrl_pkg.sv
// Shared constants for the PLL control sequencer.
// Assumes a one-bit register address space.
package pll_ctrl_pkg;
    localparam logic ADDR_RATIO  = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;
    localparam int   STAT_OFF_BIT = 2;
    localparam int   STAT_CLR_BIT = 3;
    localparam int   DATA_W       = 8;
endpackage

// File: rtl/pll_lock_timer.sv
// Lock timer: stands in for the analog lock detector by counting oscillator
// ticks after each accepted ratio write. Assumes lock_cycles is held stable
// while a count is running; 0 is treated as 1.
module pll_lock_timer #(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              osc_en,
    input  logic [LOCK_W-1:0] lock_cycles,
    output logic              locked
);
    logic [LOCK_W-1:0] cnt;
    logic [LOCK_W:0]   target;
    logic [LOCK_W:0]   next_cnt;

    // Effective target count and the incremented count.
    always_comb begin
        target   = (lock_cycles == '0) ? (LOCK_W+1)'(1) : {1'b0, lock_cycles};
        next_cnt = {1'b0, cnt} + (LOCK_W+1)'(1);
    end

    // Count oscillator ticks until the target is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (!locked && osc_en) begin
            if (next_cnt >= target) locked <= 1'b1;
            else                    cnt    <= next_cnt[LOCK_W-1:0];
        end
    end

    p_restart_drops_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);
    p_idle_never_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !locked);
endmodule

// File: rtl/pll_ctrl_regs.sv
// Register file with write-ordering rules: holds ratio, divide code,
// PLL-off and the sticky error bit. Cleared only by the main reset.
// Assumes the lock flag comes from the lock timer one register away.
module pll_ctrl_regs
    import pll_ctrl_pkg::*;
#(
    parameter int RATIO_W = 5,
    parameter int DIV_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_unlock,
    input  logic               locked,
    output logic [RATIO_W-1:0] ratio,
    output logic [DIV_W-1:0]   divsel,
    output logic               pll_off,
    output logic               wr_err,
    output logic               restart
);
    localparam logic [DIV_W-1:0] DIV_MAX = '1;

    logic               wr_ratio, wr_stat;
    logic               ratio_ok, stat_ok;
    logic [RATIO_W-1:0] new_ratio;
    logic [DIV_W-1:0]   new_div;
    logic               new_off, new_clr, active;

    // Decode the write and apply the ordering rules.
    always_comb begin
        wr_ratio  = wr_en && wr_unlock && (wr_addr == ADDR_RATIO);
        wr_stat   = wr_en && wr_unlock && (wr_addr == ADDR_STATUS);
        new_ratio = wr_data[RATIO_W-1:0];
        new_div   = wr_data[DIV_W-1:0];
        new_off   = wr_data[STAT_OFF_BIT];
        new_clr   = wr_data[STAT_CLR_BIT];
        active    = (ratio != '0);
        ratio_ok  = (divsel == '0) && !(pll_off && new_ratio != '0);
        stat_ok   = (!new_off || !active) &&
                    (!active || new_div == '0 || (locked && new_div != DIV_MAX));
        restart   = wr_ratio && ratio_ok;
    end

    // Register updates; only the main reset returns defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio   <= '0;
            divsel  <= '0;
            pll_off <= 1'b0;
            wr_err  <= 1'b0;
        end else begin
            if (restart) ratio <= new_ratio;
            if (wr_stat && stat_ok) begin
                divsel  <= new_div;
                pll_off <= new_off;
            end
            if ((wr_ratio && !ratio_ok) || (wr_stat && !stat_ok)) wr_err <= 1'b1;
            else if (wr_stat && new_clr)                          wr_err <= 1'b0;
        end
    end

    p_no_div1_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != '0) |-> (divsel != DIV_MAX));
    p_raise_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != '0 && divsel != '0) |-> locked);
    p_off_only_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off |-> (ratio == '0));
    p_protected_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_unlock) |=> ($stable(ratio) && $stable(divsel) &&
                                   $stable(pll_off) && $stable(wr_err)));
    p_ratio_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_unlock && wr_addr == ADDR_RATIO && divsel != '0)
            |=> (wr_err && $stable(ratio)));
endmodule

// File: rtl/pll_postdiv.sv
// Post-divider: counts source ticks and emits a one-cycle enable per
// divided period. A new divide code is picked up only at a period
// boundary. Code c divides by 2**(2**DIV_W-1-c).
module pll_postdiv #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_n,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] divsel,
    output logic             cpu_en
);
    localparam int MAXC = (1 << DIV_W) - 1;
    localparam int PH_W = (MAXC > 0) ? MAXC : 1;

    logic [DIV_W-1:0] d_act;
    logic [PH_W-1:0]  phase;
    logic [PH_W:0]    factor;
    logic [PH_W-1:0]  last;
    logic             wrap;

    // Division factor of the active code and period end detection.
    always_comb begin
        factor = (PH_W+1)'(1) << (MAXC - int'(d_act));
        last   = PH_W'(factor - (PH_W+1)'(1));
        wrap   = src_tick && (phase == last);
    end

    // Phase counter, boundary-aligned code pickup and enable register.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) begin
            phase  <= '0;
            d_act  <= rst_n ? divsel : '0;
            cpu_en <= 1'b0;
        end else begin
            cpu_en <= wrap;
            if (wrap) begin
                phase <= '0;
                d_act <= divsel;
            end else if (src_tick) begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    p_en_follows_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> $past(src_tick));
    p_code_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && soft_rst_n) |=> $stable(d_act));
endmodule

// File: rtl/pll_clk_ctrl.sv
// Top of the PLL control sequencer: register rules, lock timer, source
// selection and post-divider. Assumes osc_en and vco_en are tick enables
// in the clk domain.
module pll_clk_ctrl
    import pll_ctrl_pkg::*;
#(
    parameter int RATIO_W = 5,
    parameter int DIV_W   = 2,
    parameter int LOCK_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst_n,
    input  logic               osc_en,
    input  logic               vco_en,
    input  logic [LOCK_W-1:0]  lock_cycles,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               wr_unlock,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [DIV_W-1:0]   divsel_q,
    output logic               pll_off_q,
    output logic               locked_q,
    output logic               wr_err_q,
    output logic               cpu_en
);
    logic restart;
    logic src_tick;
    logic use_vco;

    pll_ctrl_regs #(.RATIO_W(RATIO_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_unlock(wr_unlock), .locked(locked_q),
        .ratio(ratio_q), .divsel(divsel_q), .pll_off(pll_off_q),
        .wr_err(wr_err_q), .restart(restart)
    );

    pll_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .run(ratio_q != '0), .osc_en(osc_en),
        .lock_cycles(lock_cycles), .locked(locked_q)
    );

    // Source select: multiplied ticks only when ratio is set, locked and on.
    always_comb begin
        use_vco  = (ratio_q != '0) && locked_q && !pll_off_q;
        src_tick = use_vco ? vco_en : osc_en;
    end

    pll_postdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .src_tick(src_tick), .divsel(divsel_q), .cpu_en(cpu_en)
    );

    p_bypass_until_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q || pll_off_q) |-> (src_tick == osc_en));
endmodule

// File: tb/pll_clk_ctrl_bench.sv
module pll_clk_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst_n = 1'b1;
    logic        osc_en = 1'b0, vco_en = 1'b1;
    logic [15:0] lock_cycles = 16'd40;
    logic        wr_en = 1'b0, wr_addr = 1'b0, wr_unlock = 1'b1;
    logic [7:0]  wr_data = 8'h00;
    logic [4:0]  ratio_q;
    logic [1:0]  divsel_q;
    logic        pll_off_q, locked_q, wr_err_q, cpu_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Oscillator ticks every second clk cycle.
    always @(negedge clk) osc_en <= ~osc_en;

    pll_clk_ctrl u_pll_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .osc_en(osc_en),
        .vco_en(vco_en), .lock_cycles(lock_cycles), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_unlock(wr_unlock),
        .ratio_q(ratio_q), .divsel_q(divsel_q), .pll_off_q(pll_off_q),
        .locked_q(locked_q), .wr_err_q(wr_err_q), .cpu_en(cpu_en)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic addr, logic [7:0] data, logic unlock);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data; wr_unlock = unlock;
        @(negedge clk);
        wr_en = 1'b0; wr_unlock = 1'b1;
    endtask

    // Cycles until the next cpu_en pulse, sampled on negedges.
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_en && n < 1000);
    endtask

    task automatic period(output int n);
        int d;
        wait_pulse(d);
        wait_pulse(d);
        wait_pulse(n);
    endtask

    task automatic t_reset;
        int p;
        check("R1", "ratio", ratio_q, 0);
        check("R1", "divsel", divsel_q, 0);
        check("R1", "off", pll_off_q, 0);
        check("R1", "locked", locked_q, 0);
        check("R1", "err", wr_err_q, 0);
        period(p);
        check("R1", "reset period", p, 16);
    endtask

    task automatic t_bypass_divs;
        int p;
        wr(1'b1, 8'h01, 1'b1); period(p); check("R2", "osc /4", p, 8);
        wr(1'b1, 8'h02, 1'b1); period(p); check("R2", "osc /2", p, 4);
        wr(1'b1, 8'h03, 1'b1); period(p); check("R2", "osc /1", p, 2);
    endtask

    task automatic t_ratio_refused;
        wr(1'b0, 8'h06, 1'b1);
        check("R3", "ratio held when div!=0", ratio_q, 0);
        check("R3", "err set", wr_err_q, 1);
        wr(1'b1, 8'h03, 1'b1);
        check("R10", "err sticky", wr_err_q, 1);
        wr(1'b1, 8'h08, 1'b1);
        check("R10", "err cleared", wr_err_q, 0);
        check("R10", "div after clear write", divsel_q, 0);
    endtask

    task automatic t_protect;
        wr(1'b0, 8'h05, 1'b0);
        check("R7", "ratio unchanged", ratio_q, 0);
        check("R7", "no err", wr_err_q, 0);
        wr(1'b1, 8'h07, 1'b0);
        check("R7", "div unchanged", divsel_q, 0);
        check("R7", "off unchanged", pll_off_q, 0);
    endtask

    task automatic t_off;
        int p;
        wr(1'b1, 8'h07, 1'b1);
        check("R6", "off set", pll_off_q, 1);
        period(p); check("R6", "off /1", p, 2);
        wr(1'b1, 8'h04, 1'b1);
        wr(1'b0, 8'h04, 1'b1);
        check("R3", "ratio refused while off", ratio_q, 0);
        check("R3", "err on off ratio", wr_err_q, 1);
        wr(1'b1, 8'h08, 1'b1);
        check("R6", "off cleared", pll_off_q, 0);
    endtask

    task automatic t_lock;
        int p, d;
        wr(1'b0, 8'h04, 1'b1);
        check("R3", "ratio accepted", ratio_q, 4);
        check("R4", "unlocked after write", locked_q, 0);
        wr(1'b1, 8'h01, 1'b1);
        check("R5", "raise before lock refused", divsel_q, 0);
        check("R5", "err on early raise", wr_err_q, 1);
        period(p);
        check("R4", "bypass period while locking", p, 16);
        check("R4", "still unlocked", locked_q, 0);
        repeat (100) @(negedge clk);
        check("R4", "locked", locked_q, 1);
        period(p);
        check("R4", "vco /8 period", p, 8);
        wr(1'b1, 8'h0B, 1'b1);
        check("R5", "/1 refused", divsel_q, 0);
        check("R10", "refused clear keeps err", wr_err_q, 1);
        wr(1'b1, 8'h0A, 1'b1);
        check("R5", "/2 accepted", divsel_q, 2);
        check("R10", "err cleared", wr_err_q, 0);
        period(p);
        check("R2", "vco /2 period", p, 2);
        wr(1'b0, 8'h00, 1'b1);
        check("R3", "ratio refused div=2", ratio_q, 4);
        wr(1'b1, 8'h0E, 1'b1);
        check("R6", "off refused ratio!=0", pll_off_q, 0);
        check("R6", "err on off", wr_err_q, 1);
        d = 0;
    endtask

    task automatic t_soft;
        @(negedge clk); soft_rst_n = 1'b0;
        @(negedge clk); soft_rst_n = 1'b1;
        check("R8", "ratio kept", ratio_q, 4);
        check("R8", "div kept", divsel_q, 2);
        check("R8", "lock kept", locked_q, 1);
        check("R8", "err kept", wr_err_q, 1);
    endtask

    task automatic t_boundary;
        int p, n;
        wr(1'b1, 8'h08, 1'b1);
        wr(1'b0, 8'h00, 1'b1);
        check("R3", "back to bypass", ratio_q, 0);
        period(p);
        check("R9", "bypass /8", p, 16);
        wait_pulse(p);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h03;
        @(negedge clk);
        wr_en = 1'b0;
        wait_pulse(n);
        check("R9", "interval across change", n + 1, 16);
        wait_pulse(n);
        check("R9", "first new interval", n, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass_divs();
        t_ratio_refused();
        t_protect();
        t_off();
        t_lock();
        t_soft();
        t_boundary();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule